// File: doc/BRIEF.md
# Two-Base Translation Table Selector

This block sits at the front of a first-level page table walk for a 32-bit virtual address space. The address space is shared between two table base registers. A small split count decides how many of the top address bits choose between them. A count of zero sends every address to the first base register. A nonzero count sends an address to the first base register only when its top bits are all zero, and to the second otherwise. The larger the count, the smaller the first table, and the lower the alignment that its base needs.

Software loads the virtual address, the two base registers and the split count through one write port. From those stored values the block gives, with no extra delay, the index of the chosen base register and the byte address of the first-level descriptor to fetch. Each descriptor is four bytes wide and maps one 1 MB section.

Top module: `tbr_sel_top`

## Requirements
- R1: Synchronous active-high reset clears the virtual address, both base registers and the split count to zero, so after reset `use_base1` is 0 and `desc_addr` is 0.
- R2: When `wr_en` is high at a rising edge, `wr_data` is stored into the register chosen by `wr_addr`, and the outputs reflect it from that edge on. The encoding is 0 = virtual address, 1 = base register 0, 2 = base register 1, 3 = split count.
- R3: With a split count of 0, `use_base1` is 0 for every virtual address.
- R4: With a split count N from 1 to 7, `use_base1` is 0 when virtual address bits [31:32-N] are all zero, and 1 otherwise.
- R5: When base register 0 is chosen, `desc_addr` bits [31:14-N] equal the same bits of base register 0. Bits [13-N:2] equal virtual address bits [31-N:20]. Bits [1:0] are zero.
- R6: When base register 1 is chosen, `desc_addr` bits [31:14] equal base register 1 bits [31:14]. Bits [13:2] equal virtual address bits [31:20]. Bits [1:0] are zero.
- R7: A write to the split count keeps only `wr_data` bits [2:0] and ignores the higher bits.
- R8: While `wr_en` is low, no register changes, whatever `wr_addr` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | 32 | Write data |
| use_base1 | output | 1 | 0 = base register 0 chosen, 1 = base register 1 chosen |
| desc_addr | output | 32 | Byte address of the first-level descriptor |

## Verification
Every result in this block is due in the first cycle after the rising edge that captured the write. No register stands between the stored values and either output. The bench therefore drives each write for one cycle and compares both outputs with its own model at the next falling edge. That falling edge lies half a period after the capturing edge. The comparison is repeated at every falling edge, so an output that settles late or changes a cycle early shows up as a mismatch. Reset is checked at the first falling edge after reset is released.

// File: rtl/tbr_sel_pkg.sv
package tbr_sel_pkg;
  typedef enum logic [1:0] {
    REG_VADDR = 2'd0,
    REG_BASE0 = 2'd1,
    REG_BASE1 = 2'd2,
    REG_SPLIT = 2'd3
  } reg_id_e;
endpackage

// File: rtl/tbr_regs.sv
module tbr_regs #(
  parameter int AW = 32,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] va_q,
  output logic [AW-1:0] base0_q,
  output logic [AW-1:0] base1_q,
  output logic [SW-1:0] split_q
);
  import tbr_sel_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      va_q    <= '0;
      base0_q <= '0;
      base1_q <= '0;
      split_q <= '0;
    end else if (wr_en) begin
      case (reg_id_e'(wr_addr))
        REG_VADDR: va_q    <= wr_data;
        REG_BASE0: base0_q <= wr_data;
        REG_BASE1: base1_q <= wr_data;
        default:   split_q <= wr_data[SW-1:0];
      endcase
    end
  end
endmodule

// File: rtl/tbr_select.sv
module tbr_select #(
  parameter int AW = 32,
  parameter int SW = 3
) (
  input  logic [AW-1:0] va,
  input  logic [SW-1:0] split,
  output logic          use1
);
  logic [AW-1:0] hi_mask;

  // The top 'split' bits are set in the mask. A split of zero gives an empty mask.
  always_comb begin
    hi_mask = ~({AW{1'b1}} >> split);
    use1    = |(va & hi_mask);
  end
endmodule

// File: rtl/tbr_desc.sv
module tbr_desc #(
  parameter int AW  = 32,
  parameter int SW  = 3,
  parameter int SEC = 20,
  parameter int ENT = 2
) (
  input  logic [AW-1:0] base0,
  input  logic [AW-1:0] base1,
  input  logic [AW-1:0] va,
  input  logic [SW-1:0] split,
  input  logic          use1,
  output logic [AW-1:0] desc
);
  localparam int TBL = AW - SEC + ENT;
  localparam logic [AW-1:0] ONES = {AW{1'b1}};

  logic [AW-1:0] idx, keep0, idx_mask0, desc0, desc1;

  always_comb begin
    idx       = va >> SEC;
    keep0     = ONES << (TBL - int'(split));
    idx_mask0 = ONES >> (SEC + int'(split));
    desc0     = (base0 & keep0) | ((idx & idx_mask0) << ENT);
    desc1     = (base1 & (ONES << TBL)) | (idx << ENT);
    desc      = use1 ? desc1 : desc0;
  end
endmodule

// File: rtl/tbr_sel_top.sv
module tbr_sel_top #(
  parameter int AW  = 32,
  parameter int SW  = 3,
  parameter int SEC = 20,
  parameter int ENT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [AW-1:0] wr_data,
  output logic          use_base1,
  output logic [AW-1:0] desc_addr
);
  import tbr_sel_pkg::*;

  localparam int TBL = AW - SEC + ENT;

  logic [AW-1:0] va_q, base0_q, base1_q;
  logic [SW-1:0] split_q;

  tbr_regs #(.AW(AW), .SW(SW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .va_q(va_q), .base0_q(base0_q), .base1_q(base1_q), .split_q(split_q)
  );

  tbr_select #(.AW(AW), .SW(SW)) u_sel (
    .va(va_q), .split(split_q), .use1(use_base1)
  );

  tbr_desc #(.AW(AW), .SW(SW), .SEC(SEC), .ENT(ENT)) u_desc (
    .base0(base0_q), .base1(base1_q), .va(va_q), .split(split_q),
    .use1(use_base1), .desc(desc_addr)
  );

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (split_q == '0 && va_q == '0 && base0_q == '0 && base1_q == '0));

  a_r2_base1_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_BASE1) |=> (base1_q == $past(wr_data)));

  a_r3_zero_split_base0: assert property (@(posedge clk) disable iff (rst)
    (split_q == '0) |-> !use_base1);

  a_r4_base0_top_bit_clear: assert property (@(posedge clk) disable iff (rst)
    (!use_base1 && split_q != '0) |-> !va_q[AW-1]);

  a_r5_word_aligned: assert property (@(posedge clk) disable iff (rst)
    desc_addr[ENT-1:0] == '0);

  a_r6_base1_high_bits: assert property (@(posedge clk) disable iff (rst)
    use_base1 |-> (desc_addr[AW-1:TBL] == base1_q[AW-1:TBL]));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(split_q) && $stable(va_q));
endmodule

// File: tb/sim_tbr_sel_top.sv
module sim_tbr_sel_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        use_base1;
  logic [31:0] desc_addr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  // Behavioural model state
  longint m_va = 0, m_b0 = 0, m_b1 = 0;
  int     m_n  = 0;

  tbr_sel_top u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .use_base1(use_base1), .desc_addr(desc_addr)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_va = 0; m_b0 = 0; m_b1 = 0; m_n = 0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: m_va = longint'(wr_data);
        2'd1: m_b0 = longint'(wr_data);
        2'd2: m_b1 = longint'(wr_data);
        default: m_n = int'(wr_data % 8);
      endcase
    end
  end

  function automatic bit model_sel();
    if (m_n == 0) return 1'b0;
    return (m_va / (longint'(1) << (32 - m_n))) != 0;
  endfunction

  function automatic longint model_desc();
    longint algn, idx;
    if (model_sel()) begin
      algn = longint'(1) << 14;
      return (m_b1 / algn) * algn + (m_va / (longint'(1) << 20)) * 4;
    end
    algn = longint'(1) << (14 - m_n);
    idx  = (m_va % (longint'(1) << (32 - m_n))) / (longint'(1) << 20);
    return (m_b0 / algn) * algn + idx * 4;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(m_n == 0 ? "R3 sel" : "R4 sel", longint'(use_base1), longint'(model_sel()));
      chk(model_sel() ? "R6 desc" : "R5 desc", longint'(desc_addr), model_desc());
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_out(input string tag, input bit es, input logic [31:0] ed);
    chk({tag, " sel"}, longint'(use_base1), longint'(es));
    chk({tag, " desc"}, longint'(desc_addr), longint'(ed));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_out("R1", 1'b0, 32'h0);

    wr(2'd1, 32'h1234_5678);
    wr(2'd2, 32'hABCD_EF12);
    wr(2'd0, 32'hFFF0_0000);
    expect_out("R3", 1'b0, 32'h1234_7FFC);
    wr(2'd0, 32'h0000_0000);
    expect_out("R2", 1'b0, 32'h1234_4000);

    wr(2'd3, 32'd2);
    wr(2'd0, 32'h3FF0_0000);
    expect_out("R5 n2", 1'b0, 32'h1234_5FFC);
    wr(2'd0, 32'h4010_0000);
    expect_out("R6 n2", 1'b1, 32'hABCD_D004);

    wr(2'd3, 32'd6);
    wr(2'd0, 32'h03F0_0000);
    expect_out("R5 n6", 1'b0, 32'h1234_56FC);
    wr(2'd0, 32'h0400_0000);
    expect_out("R4 n6", 1'b1, 32'hABCD_C100);

    wr(2'd3, 32'd7);
    wr(2'd0, 32'h01F0_0000);
    expect_out("R5 n7", 1'b0, 32'h1234_567C);

    wr(2'd3, 32'hFFFF_FFF9);
    wr(2'd0, 32'h8000_0000);
    expect_out("R7 hi", 1'b1, 32'hABCD_E000);
    wr(2'd0, 32'h7FF0_0000);
    expect_out("R7 lo", 1'b0, 32'h1234_5FFC);

    wr_addr = 2'd1; wr_data = 32'h0;
    repeat (2) @(negedge clk);
    expect_out("R8 base0", 1'b0, 32'h1234_5FFC);
    wr_addr = 2'd3; wr_data = 32'h0;
    @(negedge clk);
    expect_out("R8 split", 1'b0, 32'h1234_5FFC);

    wr(2'd3, 32'd0);
    wr(2'd0, 32'h8000_0000);
    expect_out("R3 top", 1'b0, 32'h1234_6000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule